// File: doc/BRIEF.md
# Four-Port Word Demultiplexer with Rotation Realignment

This block takes one 10-bit word per cycle of its word clock and deals the words out in a fixed rotation over four slots, A, B, C and D. The slot words are held inside the block. The four output ports change only when the D slot is filled, and then all four change on the same edge. Downstream logic therefore sees one complete four-word group at a time, at a quarter of the input word rate, and can read the group anywhere between two publications.

A data-ready strobe goes with the ports. Its rising edge marks the edge on which a new group was published. A mode input sets the strobe period to four words or to two words. A synchronous realignment input returns the rotation to slot A. The words of the group cut short are thrown away. An active-low asynchronous reset clears the block. After this reset the first incoming word is discarded, so the first word kept goes to slot B.

Top module: `quad_word_demux`

## Requirements
- R1: Accepted words fill the slots in the order A, B, C, D, and after D the rotation returns to A.
- R2: The four output ports change only on the clock edge at which a word is accepted into slot D. On that edge all four change together to the current group. At every other edge they keep their previous values.
- R3: On a publishing edge, `port_d` takes the word present on `din` at that edge, and ports A to C take the three words accepted before it in that group.
- R4: When `resync` is high at an edge, the word on `din` at that edge is not accepted, and the next word is accepted into slot A.
- R5: Words accepted in a group that a `resync` cut short never reach the ports. This holds even when the `resync` edge falls on the slot-D position. The ports keep the last completed group.
- R6: After `arst_n` is released, the first word is discarded and the second word goes to slot B. The first published group therefore shows zero on `port_a`.
- R7: While `arst_n` is low, all four ports read zero and `drdy` is low.
- R8: With `half_rate` = 0, `drdy` goes high on each publishing edge and stays high for two word periods, then low for two. With continuous input, its period is four words.
- R9: With `half_rate` = 1, `drdy` is high for one word period from the publishing edge, low for one, high for one, then low. If no new group is published, `drdy` stays low after the third word period in either mode.
- R10: `drdy` stays low after reset until the first group has been published.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock; one input word per rising edge |
| arst_n | input | 1 | Asynchronous reset, active low |
| resync | input | 1 | Synchronous rotation realignment, active high |
| half_rate | input | 1 | Strobe period select: 0 = four words, 1 = two words |
| din | input | 10 | Input word |
| port_a | output | 10 | Slot A word of the last completed group |
| port_b | output | 10 | Slot B word of the last completed group |
| port_c | output | 10 | Slot C word of the last completed group |
| port_d | output | 10 | Slot D word of the last completed group |
| drdy | output | 1 | Data-ready strobe; rises when a new group is published |

## Verification
On every cycle, the assertions check the following:
- The ports hold still unless a group completes.
- The D port takes the word present at the completing edge.
- A realignment sends the rotation to slot A.
- The rotation wraps from D to A.
- The strobe goes high on every publication and drops after a long gap.

Other behaviours need whole sequences of words, so only the bench scenarios can show them:
- The discarded first word after reset and the zero in slot A that follows from it.
- Partial groups lost to a realignment, including one that lands on the D position.
- The full strobe waveform in both modes.

// File: rtl/wdmx_pkg.sv
package wdmx_pkg;

  localparam int NUM_SLOTS = 4;

  typedef enum logic [1:0] {
    SLOT_A = 2'd0,
    SLOT_B = 2'd1,
    SLOT_C = 2'd2,
    SLOT_D = 2'd3
  } slot_t;

  // rotation step: A->B->C->D->A
  function automatic slot_t slot_after(slot_t s);
    logic [1:0] raw;
    raw = s;
    raw = raw + 2'd1;
    return slot_t'(raw);
  endfunction

  // strobe phase counter: counts word periods since the last group, stops at 3
  function automatic logic [1:0] phase_after(logic [1:0] p);
    return (p == 2'd3) ? p : p + 2'd1;
  endfunction

  // strobe level for a phase other than the publishing one (phase 0)
  function automatic logic strobe_level(logic half, logic [1:0] p);
    return half ? (p == 2'd2) : (p == 2'd1);
  endfunction

endpackage

// File: rtl/wdmx_rotor.sv
module wdmx_rotor
  import wdmx_pkg::*;
(
  input  logic  clk,
  input  logic  arst_n,
  input  logic  resync,
  output slot_t sel_q,
  output logic  take_word,
  output logic  group_done
);

  logic drop_q;

  // a word is accepted unless a realignment is seen or the post-reset drop is pending
  assign take_word  = !resync && !drop_q;
  assign group_done = take_word && (sel_q == SLOT_D);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sel_q  <= SLOT_A;
      drop_q <= 1'b1;
    end else if (resync) begin
      sel_q  <= SLOT_A;
      drop_q <= 1'b0;
    end else begin
      sel_q  <= slot_after(sel_q);
      drop_q <= 1'b0;
    end
  end

  assert_resync_to_a_R4: assert property (@(posedge clk) disable iff (!arst_n)
    resync |=> (sel_q == SLOT_A));

  assert_wrap_after_d_R1: assert property (@(posedge clk) disable iff (!arst_n)
    (sel_q == SLOT_D && !resync) |=> (sel_q == SLOT_A));

  assert_drop_only_first_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (!resync && $past(!resync)) |-> (take_word || $past(take_word) || $past(drop_q)));

endmodule

// File: rtl/wdmx_bank.sv
module wdmx_bank
  import wdmx_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic                                clk,
  input  logic                                arst_n,
  input  slot_t                               sel,
  input  logic                                take_word,
  input  logic                                group_done,
  input  logic [WIDTH-1:0]                    din,
  output logic [NUM_SLOTS-1:0][WIDTH-1:0]     ports_q
);

  localparam int HELD = NUM_SLOTS - 1;

  logic [HELD-1:0][WIDTH-1:0] slot_q;

  // slots A..C are held internally; slot D goes straight to the ports
  for (genvar g = 0; g < HELD; g++) begin : g_slot
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
        slot_q[g] <= '0;
      else if (take_word && (sel == slot_t'(g)))
        slot_q[g] <= din;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ports_q <= '0;
    end else if (group_done) begin
      for (int i = 0; i < HELD; i++)
        ports_q[i] <= slot_q[i];
      ports_q[NUM_SLOTS-1] <= din;
    end
  end

  assert_hold_between_groups_R2: assert property (@(posedge clk) disable iff (!arst_n)
    !group_done |=> $stable(ports_q));

  assert_d_takes_live_word_R3: assert property (@(posedge clk) disable iff (!arst_n)
    group_done |=> (ports_q[NUM_SLOTS-1] == $past(din)));

endmodule

// File: rtl/wdmx_strobe.sv
module wdmx_strobe
  import wdmx_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic half_rate,
  input  logic group_done,
  output logic drdy_q
);

  logic [1:0] phase_q;
  logic       live_q;
  logic [1:0] phase_nx;

  assign phase_nx = phase_after(phase_q);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase_q <= 2'd3;
      live_q  <= 1'b0;
      drdy_q  <= 1'b0;
    end else if (group_done) begin
      phase_q <= 2'd0;
      live_q  <= 1'b1;
      drdy_q  <= 1'b1;
    end else begin
      phase_q <= phase_nx;
      drdy_q  <= live_q && strobe_level(half_rate, phase_nx);
    end
  end

  assert_strobe_on_group_R8: assert property (@(posedge clk) disable iff (!arst_n)
    group_done |=> drdy_q);

  assert_strobe_quiet_gap_R9: assert property (@(posedge clk) disable iff (!arst_n)
    (!group_done && phase_q == 2'd3) |=> !drdy_q);

endmodule

// File: rtl/quad_word_demux.sv
module quad_word_demux
  import wdmx_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             resync,
  input  logic             half_rate,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] port_a,
  output logic [WIDTH-1:0] port_b,
  output logic [WIDTH-1:0] port_c,
  output logic [WIDTH-1:0] port_d,
  output logic             drdy
);

  slot_t                            sel;
  logic                             take_word;
  logic                             group_done;
  logic [NUM_SLOTS-1:0][WIDTH-1:0]  ports;

  wdmx_rotor u_rotor (
    .clk        (clk),
    .arst_n     (arst_n),
    .resync     (resync),
    .sel_q      (sel),
    .take_word  (take_word),
    .group_done (group_done)
  );

  wdmx_bank #(.WIDTH(WIDTH)) u_bank (
    .clk        (clk),
    .arst_n     (arst_n),
    .sel        (sel),
    .take_word  (take_word),
    .group_done (group_done),
    .din        (din),
    .ports_q    (ports)
  );

  wdmx_strobe u_strobe (
    .clk        (clk),
    .arst_n     (arst_n),
    .half_rate  (half_rate),
    .group_done (group_done),
    .drdy_q     (drdy)
  );

  assign port_a = ports[SLOT_A];
  assign port_b = ports[SLOT_B];
  assign port_c = ports[SLOT_C];
  assign port_d = ports[SLOT_D];

  assert_no_publish_on_resync_R5: assert property (@(posedge clk) disable iff (!arst_n)
    resync |=> $stable({port_a, port_b, port_c, port_d}));

endmodule

// File: tb/quad_word_demux_test.sv
`timescale 1ns/1ps
module quad_word_demux_test;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       resync = 1'b0;
  logic       half_rate = 1'b0;
  logic [9:0] din = '0;
  logic [9:0] port_a, port_b, port_c, port_d;
  logic       drdy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [9:0] grp [4];
  logic [9:0] shown [4];
  int  slot_idx;
  bit  skip_next;
  int  gap;
  bit  seen_group;
  bit  exp_drdy;
  bit  published;

  always #2.5 clk = ~clk;

  quad_word_demux uut (
    .clk(clk), .arst_n(arst_n), .resync(resync), .half_rate(half_rate),
    .din(din), .port_a(port_a), .port_b(port_b), .port_c(port_c),
    .port_d(port_d), .drdy(drdy)
  );

  function automatic bit strobe_expect(bit half, int g, bit seen);
    if (!seen) return 0;
    if (g == 0) return 1;
    return half ? (g == 2) : (g == 1);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin grp[i] = '0; shown[i] = '0; end
    slot_idx = 0; skip_next = 1; gap = 3; seen_group = 0; exp_drdy = 0;
  endtask

  task automatic model_edge(bit rs, logic [9:0] w, bit half);
    published = 0;
    if (rs) begin
      slot_idx = 0; skip_next = 0;
    end else if (skip_next) begin
      skip_next = 0; slot_idx = 1;
    end else begin
      grp[slot_idx] = w;
      if (slot_idx == 3) published = 1;
      slot_idx = (slot_idx + 1) % 4;
    end
    if (published) begin
      for (int i = 0; i < 4; i++) shown[i] = grp[i];
      gap = 0; seen_group = 1;
    end else if (gap < 3) gap++;
    exp_drdy = strobe_expect(half, gap, seen_group);
  endtask

  task automatic check(string tag, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string ptag, string stag);
    check(ptag, {port_a, port_b, port_c, port_d}, {shown[0], shown[1], shown[2], shown[3]});
    check(stag, {39'd0, drdy}, {39'd0, exp_drdy});
  endtask

  // drive at the falling edge, let one rising edge pass, compare at the next falling edge
  task automatic step(bit rs, logic [9:0] w, string ptag, string stag);
    resync = rs; din = w;
    @(posedge clk);
    model_edge(rs, w, half_rate);
    @(negedge clk);
    check_all(ptag, stag);
  endtask

  task automatic do_reset();
    arst_n = 1'b0;
    #1;
    check("R7", {port_a, port_b, port_c, port_d}, 40'd0);
    check("R7", {39'd0, drdy}, 40'd0);
    model_reset();
    @(negedge clk);
    check("R7", {port_a, port_b, port_c, port_d, drdy}, 41'd0);
    arst_n = 1'b1;
  endtask

  initial begin
    #900000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    @(negedge clk);
    do_reset();

    // R6 R10: first word dropped, second on B, slot A zero
    step(0, 10'h101, "R6", "R10");
    step(0, 10'h102, "R6", "R10");
    step(0, 10'h103, "R6", "R10");
    step(0, 10'h104, "R6", "R8");
    check("R6", {port_a, port_b, port_c, port_d}, {10'h000, 10'h102, 10'h103, 10'h104});

    // R1 R3: full group in order
    for (int i = 0; i < 4; i++) step(0, 10'h200 + 10'(i), "R1", "R8");
    check("R3", {port_a, port_b, port_c, port_d}, {10'h200, 10'h201, 10'h202, 10'h203});

    // R4 R5: realign after two words, partial group lost
    step(0, 10'h301, "R5", "R8");
    step(0, 10'h302, "R5", "R8");
    step(1, 10'h3FF, "R5", "R9");
    check("R5", {port_a, port_b, port_c, port_d}, {10'h200, 10'h201, 10'h202, 10'h203});
    for (int i = 0; i < 4; i++) step(0, 10'h310 + 10'(i), "R4", "R8");
    check("R4", {port_a, port_b, port_c, port_d}, {10'h310, 10'h311, 10'h312, 10'h313});

    // R5: realignment on the D position publishes nothing
    step(0, 10'h041, "R5", "R8");
    step(0, 10'h042, "R5", "R8");
    step(0, 10'h043, "R5", "R8");
    step(1, 10'h044, "R5", "R9");
    check("R5", {port_a, port_b, port_c, port_d}, {10'h310, 10'h311, 10'h312, 10'h313});

    // R9: repeated realignment keeps strobe low after the gap
    for (int i = 0; i < 5; i++) step(1, 10'h055, "R5", "R9");
    check("R9", {39'd0, drdy}, 40'd0);

    // R9: half-rate strobe pattern
    half_rate = 1'b1;
    for (int i = 0; i < 12; i++) step(0, 10'(i * 37), "R2", "R9");

    // R7: reset in the middle of a run, then R6 again
    half_rate = 1'b0;
    step(0, 10'h0AA, "R2", "R8");
    do_reset();
    step(0, 10'h111, "R6", "R10");
    for (int i = 0; i < 3; i++) step(0, 10'h120 + 10'(i), "R6", "R8");
    check("R6", {port_a, port_b, port_c, port_d}, {10'h000, 10'h120, 10'h121, 10'h122});

    // random stream with occasional realignment and mode changes
    for (int n = 0; n < 4000; n++) begin
      if (n % 250 == 0) half_rate = 1'($urandom_range(0, 1));
      step(($urandom_range(0, 15) == 0), 10'($urandom), "R2", half_rate ? "R9" : "R8");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule